// File: doc/BRIEF.md
# Buck Channel Operating-Mode Selector

This block picks how one synchronous buck channel switches. At heavy load it runs in fixed-frequency PWM, where the high-side request follows the PWM latch and the low-side request is its complement. At light load it runs in hysteretic mode with diode emulation. In that mode a high-side pulse starts on a switching tick when the output is below the lower comparator limit. The pulse ends when the output reaches the upper limit, and both switches stay off between pulses.

The move between modes is decided by the phase-node sign. A comparator reports that sign once per switching period, on the `smp_en` tick that falls at the end of low-side conduction. Eight samples in a row that point toward the other mode are needed before the mode changes, so the mode does not chatter near the boundary. A sudden output dip while in hysteretic mode returns the channel to PWM on the next clock. A break-before-make stage sits between the requests and the outputs. It holds each gate request back until the opposite driver reports its gate low, and until that gate was off in the previous cycle.

Top module: `buck_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and on release, `hs_req` and `ls_req` are 0, `mode_hyst` is 0 (PWM) and `run_cnt` is 0.
- R2: In PWM mode (`mode_hyst`=0), each `smp_en` cycle with `phase_pos`=1 adds one to `run_cnt`. The eighth such sample in a row sets `mode_hyst` to 1 at that clock edge, and seven are not enough.
- R3: A sample of the polarity that keeps the current mode clears `run_cnt` to 0. Cycles with `smp_en`=0 leave `run_cnt` unchanged, except for a fast-path return (R5).
- R4: In hysteretic mode, eight `smp_en` samples in a row with `phase_pos`=0 set `mode_hyst` back to 0 at the eighth sample's edge.
- R5: In hysteretic mode, `v_dip`=1 sets `mode_hyst` to 0 and `run_cnt` to 0 at the next clock edge, whether or not `smp_en` is high. In PWM mode `v_dip` has no effect.
- R6: In PWM mode, with both gate-low feedback bits true, `hs_req` follows `pwm_on` and `ls_req` follows its complement, one clock edge after the input. When one request hands over to the other, there is one extra cycle with both requests at 0.
- R7: In hysteretic mode, `ls_req` stays 0 and `pwm_on` has no effect. `hs_req` rises one edge after an `smp_en` cycle with `v_below_lo`=1, stays high until the edge after `v_above_hi`=1, and then stays 0.
- R8: In the first cycle after `mode_hyst` changes, both `hs_req` and `ls_req` are 0.
- R9: `hs_req` and `ls_req` are never both 1. `ls_req` does not rise while `hs_gate_low` is 0, and `hs_req` does not rise while `ls_gate_low` is 0.
- R10: `run_cnt` reads 0 after every mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Switching tick; phase sign is sampled here and hysteretic pulses start here |
| phase_pos | input | 1 | Phase comparator: 1 = phase node positive during low-side conduction |
| pwm_on | input | 1 | PWM latch output: 1 requests high-side on |
| v_below_lo | input | 1 | Output below the lower hysteretic limit |
| v_above_hi | input | 1 | Output at or above the upper hysteretic limit |
| v_dip | input | 1 | Output fell below the hysteretic regulation level |
| hs_gate_low | input | 1 | High-side driver reports its gate low |
| ls_gate_low | input | 1 | Low-side driver reports its gate low |
| hs_req | output | 1 | High-side gate request |
| ls_req | output | 1 | Low-side gate request |
| mode_hyst | output | 1 | 1 = hysteretic mode, 0 = PWM |
| run_cnt | output | RUN_LEN bits log2 (3) | Same-direction sample run length |

## Verification
Every output is registered once. The mode flag and run counter therefore change at the first edge after the sample or dip that causes them. A gate request changes one edge after its cause, and a hand-over between the two gates takes two edges. The bench drives inputs 2 ns after a rising edge and reads the outputs 2 ns after the next rising edge. For each check it counts edges exactly as stated above: one edge per count step, one edge for a mode change, and two edges for a gate hand-over. Stuck gate-low feedback is applied for several edges to show that the blocked gate stays off the whole time.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_HYST = 1'b1
  } mode_e;

  // A sample counts toward leaving the current mode when its sign
  // is the one the other mode would see.
  function automatic logic toward_other(input mode_e mode, input logic phase_pos);
    return (mode == MODE_PWM) ? phase_pos : ~phase_pos;
  endfunction

  function automatic mode_e other_mode(input mode_e mode);
    return (mode == MODE_PWM) ? MODE_HYST : MODE_PWM;
  endfunction

endpackage

// File: rtl/mode_debounce.sv
module mode_debounce
  import buck_mode_pkg::*;
#(
  parameter int RUN_LEN = 8,
  localparam int CNT_W = $clog2(RUN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             phase_pos,
  input  logic             v_dip,
  output mode_e            mode_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flip
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic toward;
  logic fast_back;
  logic run_done;

  assign toward    = toward_other(mode_q, phase_pos);
  assign fast_back = (mode_q == MODE_HYST) && v_dip;
  assign run_done  = smp_en && toward && (cnt_q == LAST);
  assign flip      = fast_back || run_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_PWM;
      cnt_q  <= '0;
    end else if (flip) begin
      mode_q <= other_mode(mode_q);
      cnt_q  <= '0;
    end else if (smp_en) begin
      cnt_q  <= toward ? cnt_q + 1'b1 : '0;
    end
  end

  assert_fast_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HYST && v_dip) |=> (mode_q == MODE_PWM && cnt_q == '0));

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_en && !v_dip) |=> $stable(cnt_q) && $stable(mode_q));

  assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/gate_request.sv
module gate_request
  import buck_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_q,
  input  logic  flip,
  input  logic  smp_en,
  input  logic  pwm_on,
  input  logic  v_below_lo,
  input  logic  v_above_hi,
  output logic  want_hi,
  output logic  want_lo
);

  logic hpulse_q;
  logic hpulse_d;

  // Hysteretic on-pulse: opens on a switching tick below the lower limit,
  // closes when the upper limit is reached.
  always_comb begin
    if (flip || mode_q != MODE_HYST) hpulse_d = 1'b0;
    else if (hpulse_q)               hpulse_d = ~v_above_hi;
    else                             hpulse_d = smp_en & v_below_lo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hpulse_q <= 1'b0;
    else        hpulse_q <= hpulse_d;
  end

  always_comb begin
    if (flip) begin
      want_hi = 1'b0;
      want_lo = 1'b0;
    end else if (mode_q == MODE_PWM) begin
      want_hi = pwm_on;
      want_lo = ~pwm_on;
    end else begin
      want_hi = hpulse_d;
      want_lo = 1'b0;
    end
  end

  assert_pulse_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hpulse_q) |-> $past(smp_en) && $past(v_below_lo));

endmodule

// File: rtl/bbm_interlock.sv
module bbm_interlock (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hi,
  input  logic want_lo,
  input  logic hs_gate_low,
  input  logic ls_gate_low,
  output logic hs_q,
  output logic ls_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= want_hi & ls_gate_low & ~ls_q;
      ls_q <= want_lo & hs_gate_low & ~hs_q;
    end
  end

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));

  assert_hs_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> $past(ls_gate_low) && !$past(ls_q));

  assert_ls_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> $past(hs_gate_low) && !$past(hs_q));

endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
  import buck_mode_pkg::*;
#(
  parameter int RUN_LEN = 8,
  localparam int CNT_W = $clog2(RUN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             phase_pos,
  input  logic             pwm_on,
  input  logic             v_below_lo,
  input  logic             v_above_hi,
  input  logic             v_dip,
  input  logic             hs_gate_low,
  input  logic             ls_gate_low,
  output logic             hs_req,
  output logic             ls_req,
  output logic             mode_hyst,
  output logic [CNT_W-1:0] run_cnt
);

  mode_e mode_q;
  logic  flip;
  logic  want_hi;
  logic  want_lo;

  mode_debounce #(.RUN_LEN(RUN_LEN)) u_debounce (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (smp_en),
    .phase_pos (phase_pos),
    .v_dip     (v_dip),
    .mode_q    (mode_q),
    .cnt_q     (run_cnt),
    .flip      (flip)
  );

  gate_request u_request (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .flip       (flip),
    .smp_en     (smp_en),
    .pwm_on     (pwm_on),
    .v_below_lo (v_below_lo),
    .v_above_hi (v_above_hi),
    .want_hi    (want_hi),
    .want_lo    (want_lo)
  );

  bbm_interlock u_interlock (
    .clk         (clk),
    .rst_n       (rst_n),
    .want_hi     (want_hi),
    .want_lo     (want_lo),
    .hs_gate_low (hs_gate_low),
    .ls_gate_low (ls_gate_low),
    .hs_q        (hs_req),
    .ls_q        (ls_req)
  );

  assign mode_hyst = (mode_q == MODE_HYST);

  assert_flip_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hyst != $past(mode_hyst)) |-> (!hs_req && !ls_req));

  assert_hyst_no_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hyst && $past(mode_hyst)) |-> !ls_req);

endmodule

// File: tb/buck_mode_ctrl_bench.sv
module buck_mode_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0, phase_pos = 1'b0, pwm_on = 1'b0;
  logic v_below_lo = 1'b0, v_above_hi = 1'b0, v_dip = 1'b0;
  logic hs_stuck = 1'b0, ls_stuck = 1'b0;
  logic hs_gate_low, ls_gate_low;
  logic hs_req, ls_req, mode_hyst;
  logic [2:0] run_cnt;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // Simple driver model: gate reads low whenever its request is off.
  assign hs_gate_low = ~hs_req & ~hs_stuck;
  assign ls_gate_low = ~ls_req & ~ls_stuck;

  buck_mode_ctrl u_buck_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .phase_pos(phase_pos),
    .pwm_on(pwm_on), .v_below_lo(v_below_lo), .v_above_hi(v_above_hi),
    .v_dip(v_dip), .hs_gate_low(hs_gate_low), .ls_gate_low(ls_gate_low),
    .hs_req(hs_req), .ls_req(ls_req), .mode_hyst(mode_hyst), .run_cnt(run_cnt)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int hs, input int ls, input int md, input int cnt);
    chk(req, "hs_req", hs_req, hs);
    chk(req, "ls_req", ls_req, ls);
    chk(req, "mode_hyst", mode_hyst, md);
    chk(req, "run_cnt", run_cnt, cnt);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk_state("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    chk_state("R1", 0, 0, 0, 0);
  endtask

  task automatic t_pwm_gates();
    pwm_on = 1'b0; step();
    chk_state("R6", 0, 1, 0, 0);
    pwm_on = 1'b1; step();
    chk_state("R6", 0, 0, 0, 0);
    step();
    chk_state("R6", 1, 0, 0, 0);
    pwm_on = 1'b0; step();
    chk_state("R6", 0, 0, 0, 0);
    step();
    chk_state("R6", 0, 1, 0, 0);
  endtask

  task automatic t_to_hyst();
    smp_en = 1'b1; phase_pos = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      step();
      chk_state("R2", 0, 1, 0, i);
    end
    phase_pos = 1'b0; step();
    chk_state("R3", 0, 1, 0, 0);
    smp_en = 1'b0; phase_pos = 1'b1;
    repeat (3) step();
    chk_state("R3", 0, 1, 0, 0);
    smp_en = 1'b1;
    repeat (3) step();
    chk_state("R2", 0, 1, 0, 3);
    smp_en = 1'b0;
    repeat (2) step();
    chk_state("R3", 0, 1, 0, 3);
    smp_en = 1'b1;
    repeat (4) step();
    chk_state("R2", 0, 1, 0, 7);
    step();
    chk_state("R8_R10", 0, 0, 1, 0);
  endtask

  task automatic t_hyst_pulse();
    smp_en = 1'b0; phase_pos = 1'b1; pwm_on = 1'b1;
    step();
    chk_state("R7", 0, 0, 1, 0);
    v_below_lo = 1'b1; step();
    chk_state("R7", 0, 0, 1, 0);
    smp_en = 1'b1; step();
    chk_state("R7", 1, 0, 1, 0);
    smp_en = 1'b0; v_below_lo = 1'b0; step();
    chk_state("R7", 1, 0, 1, 0);
    v_above_hi = 1'b1; step();
    chk_state("R7", 0, 0, 1, 0);
    v_above_hi = 1'b0; pwm_on = 1'b0;
    repeat (3) step();
    chk_state("R7", 0, 0, 1, 0);
  endtask

  task automatic t_back_to_pwm();
    smp_en = 1'b1; phase_pos = 1'b0; pwm_on = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      step();
      chk_state("R4", 0, 0, 1, i);
    end
    step();
    chk_state("R4_R8", 0, 0, 0, 0);
    smp_en = 1'b0; step();
    chk_state("R6", 1, 0, 0, 0);
  endtask

  task automatic t_fast_path();
    v_dip = 1'b1; step();
    chk_state("R5", 1, 0, 0, 0);
    v_dip = 1'b0;
    smp_en = 1'b1; phase_pos = 1'b1;
    repeat (8) step();
    chk_state("R2", 0, 0, 1, 0);
    phase_pos = 1'b0;
    repeat (3) step();
    chk_state("R4", 0, 0, 1, 3);
    smp_en = 1'b0; v_dip = 1'b1; step();
    chk_state("R5", 0, 0, 0, 0);
    v_dip = 1'b0; step();
    chk_state("R5", 1, 0, 0, 0);
  endtask

  task automatic t_interlock();
    hs_stuck = 1'b1; pwm_on = 1'b0; step();
    chk_state("R9", 0, 0, 0, 0);
    repeat (4) step();
    chk_state("R9", 0, 0, 0, 0);
    hs_stuck = 1'b0; step();
    chk_state("R9", 0, 1, 0, 0);
    ls_stuck = 1'b1; pwm_on = 1'b1; step();
    chk_state("R9", 0, 0, 0, 0);
    repeat (4) step();
    chk_state("R9", 0, 0, 0, 0);
    ls_stuck = 1'b0; step();
    chk_state("R9", 1, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_pwm_gates();
    t_to_hyst();
    t_hyst_pulse();
    t_back_to_pwm();
    t_fast_path();
    t_interlock();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule